// File: doc/BRIEF.md
# Burst Read Sequencer

This block is the read engine on the device side of a burst-capable memory port. A 16-bit configuration word sets the read mode, the initial latency, the polarity and timing of the ready strobe, whether a burst wraps, and the burst length. An address is captured on a rising clock edge when both chip select and the address strobe are high. After that capture the engine waits for the programmed latency. It then presents one word per clock from a modelled storage array. The engine steps the address itself, either linearly or wrapping inside an aligned block, and drives a ready strobe that can be inverted and can lead the data by one clock.

The configuration word is written through a plain write port and can always be read back. The configuration for a burst is taken at the moment the address is captured. While a burst is in progress, writes are refused.

Top module: `burst_read_seq`

## Requirements
- R1: After reset the configuration reads back 16'hAFC8. This means asynchronous mode, latency code 101, ready active high and aligned, wrap on, and continuous length. While chip select is low, `dataValid` and `rdyOut` are 0.
- R2: In asynchronous mode (bit 15 = 1), capturing an address gives exactly one valid word at that address right after the capturing edge. On the following edge `dataValid` falls.
- R3: In synchronous mode (bit 15 = 0), latency code c in bits 13:11 (values 000 to 101) places the first word on rising edge number c+2 after the capture edge. For example, code 011 gives edge 5 and code 101 gives edge 7. Edges 1 to c+1 show no valid data.
- R4: Bit 10 selects the ready polarity. With 1, ready is high when active. With 0, ready is low when active. When inactive, ready sits at the opposite level.
- R5: With bit 8 = 0 and a nonzero latency code, ready becomes active one clock before the first word. It stays active until one clock before the last word. With bit 8 = 1, ready is active exactly while `dataValid` is high.
- R6: With latency code 000 (first word on edge 2), ready is aligned with data whatever the value of bit 8.
- R7: Bits 2:0 select the burst length: 010 gives 8 words, 011 gives 16, 100 gives 32, and 000 is continuous. With bit 3 = 1, a finite burst wraps modulo its length inside the aligned block that holds the start address.
- R8: With bit 3 = 0, a finite burst counts up linearly across the block boundary. Either way it ends after the programmed number of words.
- R9: A continuous burst increments the address without limit, wrapping modulo 2^ADDR_W. Dropping chip select at any point clears `dataValid` and returns ready to its inactive level in the same cycle.
- R10: Only bits 15, 13:11, 10, 8, 3 and 2:0 are writable. Bits 9, 7 and 6 read 1, and bits 14, 5 and 4 read 0.
- R11: A reserved latency code (110 or 111) behaves as code 101. A reserved length code (001, 101, 110 or 111) behaves as continuous.
- R12: A write is ignored while a synchronous burst is waiting or streaming. Dropping chip select leaves the configuration unchanged.
- R13: The word returned for address A is the low DATA_W bits of A XOR 16'h5A00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWe | input | 1 | Configuration write strobe |
| cfgWdata | input | 16 | Configuration write value |
| cfgRdata | output | 16 | Configuration read-back |
| chipSel | input | 1 | Chip select, active high |
| addrValid | input | 1 | Address capture strobe |
| addrIn | input | ADDR_W | Start address |
| dataOut | output | DATA_W | Read word |
| dataValid | output | 1 | dataOut holds a burst word |
| rdyOut | output | 1 | Ready strobe, polarity and timing per configuration |

## Verification
The bench counts edges from the capture edge for each latency code. A latency off by one register would put the first word one sample early or late. The bench follows wrap bursts across the block edge, where a design that ignored the aligned base would run on into the next block, and it follows linear bursts across the block edge, where a design that wrapped anyway would fold back. The bench also checks the early-ready window in inverted polarity and the zero-latency override. A wrong lead would show ready one cycle late or still active on the last word. Finally, the bench drops chip select in the middle of a continuous run and writes during a burst: a lazy abort would leave one extra valid word, and an unguarded write would change the read-back.

// File: rtl/burst_read_pkg.sv
package burst_read_pkg;

  localparam int CFG_W = 16;
  localparam int LAT_W = 4;
  localparam int LEN_W = 6;

  localparam logic [CFG_W-1:0] CFG_DEFAULT = 16'hAFC8;
  localparam logic [CFG_W-1:0] CFG_WMASK   = 16'hBD0F;
  localparam logic [CFG_W-1:0] CFG_FIXED   = 16'h02C0;

  typedef struct packed {
    logic load;
    logic step;
  } seq_strobe_t;

  typedef struct packed {
    logic             asyncMode;
    logic [LAT_W-1:0] latency;
    logic             rdyHigh;
    logic             rdyEarly;
    logic             wrapOn;
    logic [LEN_W-1:0] burstLen;
  } read_cfg_t;

  function automatic read_cfg_t decodeCfg(input logic [CFG_W-1:0] raw);
    read_cfg_t d;
    logic [2:0] latCode;
    latCode     = raw[13:11];
    d.asyncMode = raw[15];
    d.rdyHigh   = raw[10];
    d.wrapOn    = raw[3];
    if (latCode <= 3'd5) d.latency = LAT_W'(latCode) + LAT_W'(2);
    else                 d.latency = LAT_W'(7);
    d.rdyEarly  = !raw[8] && (latCode != 3'b000);
    case (raw[2:0])
      3'b010:  d.burstLen = LEN_W'(8);
      3'b011:  d.burstLen = LEN_W'(16);
      3'b100:  d.burstLen = LEN_W'(32);
      default: d.burstLen = '0;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/burst_cfg_reg.sv
module burst_cfg_reg
  import burst_read_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             wrAllow,
  input  logic [CFG_W-1:0] wrData,
  output logic [CFG_W-1:0] cfgRaw,
  output read_cfg_t        cfgDec
);

  logic [CFG_W-1:0] cfgQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                cfgQ <= CFG_DEFAULT;
    else if (wrEn && wrAllow) cfgQ <= (wrData & CFG_WMASK) | CFG_FIXED;
  end

  assign cfgRaw = cfgQ;
  assign cfgDec = decodeCfg(cfgQ);

endmodule

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_read_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        chipSel,
  input  logic        addrValid,
  input  read_cfg_t   cfg,
  output seq_strobe_t strobe,
  output logic        dataValid,
  output logic        rdyOut,
  output logic        busy
);

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_DATA} seq_state_e;

  seq_state_e       state;
  logic [LAT_W-1:0] latCnt;
  logic [LEN_W-1:0] wordsLeft;
  logic             contMode;
  logic             earlyMode;
  logic             validReg;

  logic latchNow, moreWords, fireFirst, streamOn, validNext, rdyActive;

  assign latchNow  = chipSel && addrValid;
  assign moreWords = contMode || (wordsLeft != '0);
  assign fireFirst = (state == ST_WAIT) && (latCnt == '0);
  assign streamOn  = chipSel && !addrValid;
  assign validNext = streamOn && (fireFirst || ((state == ST_DATA) && moreWords));

  always_comb begin
    strobe      = '0;
    strobe.load = latchNow;
    strobe.step = streamOn && (state == ST_DATA) && moreWords;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      latCnt    <= '0;
      wordsLeft <= '0;
      contMode  <= 1'b0;
      earlyMode <= 1'b0;
      validReg  <= 1'b0;
    end else if (!chipSel) begin
      state    <= ST_IDLE;
      validReg <= 1'b0;
    end else if (addrValid) begin
      if (cfg.asyncMode) begin
        state     <= ST_IDLE;
        validReg  <= 1'b1;
        earlyMode <= 1'b0;
      end else begin
        state     <= ST_WAIT;
        validReg  <= 1'b0;
        latCnt    <= cfg.latency - LAT_W'(1);
        wordsLeft <= cfg.burstLen - LEN_W'(1);
        contMode  <= (cfg.burstLen == '0);
        earlyMode <= cfg.rdyEarly;
      end
    end else begin
      case (state)
        ST_WAIT: begin
          if (latCnt == '0) begin
            state    <= ST_DATA;
            validReg <= 1'b1;
          end else begin
            latCnt <= latCnt - LAT_W'(1);
          end
        end
        ST_DATA: begin
          if (moreWords) begin
            if (!contMode) wordsLeft <= wordsLeft - LEN_W'(1);
          end else begin
            state    <= ST_IDLE;
            validReg <= 1'b0;
          end
        end
        default: begin
          state    <= ST_IDLE;
          validReg <= 1'b0;
        end
      endcase
    end
  end

  assign dataValid = validReg && chipSel;
  assign rdyActive = earlyMode ? validNext : dataValid;
  assign rdyOut    = cfg.rdyHigh ? rdyActive : !rdyActive;
  assign busy      = (state != ST_IDLE);

endmodule

// File: rtl/burst_seq_dpath.sv
module burst_seq_dpath
  import burst_read_pkg::*;
#(
  parameter int              ADDR_W  = 16,
  parameter int              DATA_W  = 16,
  parameter logic [DATA_W-1:0] PATTERN = DATA_W'(16'h5A00)
) (
  input  logic              clk,
  input  logic              rstN,
  input  seq_strobe_t       strobe,
  input  read_cfg_t         cfg,
  input  logic [ADDR_W-1:0] addrIn,
  output logic [DATA_W-1:0] dataOut
);

  logic [ADDR_W-1:0] addrReg;
  logic [ADDR_W-1:0] lenMask;
  logic              wrapEff;
  logic [ADDR_W-1:0] addrInc;
  logic [ADDR_W-1:0] addrNext;

  assign addrInc  = addrReg + ADDR_W'(1);
  assign addrNext = wrapEff ? ((addrReg & ~lenMask) | (addrInc & lenMask)) : addrInc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= '0;
      lenMask <= '0;
      wrapEff <= 1'b0;
    end else if (strobe.load) begin
      addrReg <= addrIn;
      lenMask <= ADDR_W'(cfg.burstLen) - ADDR_W'(1);
      wrapEff <= cfg.wrapOn && (cfg.burstLen != '0);
    end else if (strobe.step) begin
      addrReg <= addrNext;
    end
  end

  // storage model: each word is its address folded with a fixed pattern
  assign dataOut = DATA_W'(addrReg) ^ PATTERN;

endmodule

// File: rtl/burst_read_seq.sv
module burst_read_seq
  import burst_read_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [15:0]       cfgWdata,
  output logic [15:0]       cfgRdata,
  input  logic              chipSel,
  input  logic              addrValid,
  input  logic [ADDR_W-1:0] addrIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataValid,
  output logic              rdyOut
);

  read_cfg_t   cfgDec;
  seq_strobe_t strobe;
  logic        engineBusy;

  burst_cfg_reg u_cfg (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (cfgWe),
    .wrAllow(!engineBusy),
    .wrData (cfgWdata),
    .cfgRaw (cfgRdata),
    .cfgDec (cfgDec)
  );

  burst_seq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .chipSel  (chipSel),
    .addrValid(addrValid),
    .cfg      (cfgDec),
    .strobe   (strobe),
    .dataValid(dataValid),
    .rdyOut   (rdyOut),
    .busy     (engineBusy)
  );

  burst_seq_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .cfg    (cfgDec),
    .addrIn (addrIn),
    .dataOut(dataOut)
  );

endmodule

// File: rtl/burst_read_seq_chk.sv
module burst_read_seq_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              chipSel,
  input logic              cfgWe,
  input logic [15:0]       cfgRdata,
  input logic [DATA_W-1:0] dataOut,
  input logic              dataValid,
  input logic              rdyOut,
  input logic              engineBusy
);

  // R1: register holds its default on the first edge out of reset
  a_r1_reset_default: assert property (@(posedge clk)
    $rose(rstN) |-> cfgRdata == 16'hAFC8);

  // R12: no configuration change lands while the engine is busy
  a_r12_cfg_frozen: assert property (@(posedge clk) disable iff (!rstN)
    engineBusy |=> $stable(cfgRdata));

  // R9: a deselected cycle leaves no valid word on the following cycle
  a_r9_ce_abort: assert property (@(posedge clk) disable iff (!rstN)
    !chipSel |=> !dataValid || chipSel);

  // R4: deselected ready sits at the inactive level of the programmed polarity
  a_r4_idle_level: assert property (@(posedge clk) disable iff (!rstN)
    !chipSel |-> rdyOut == !cfgRdata[10]);

  // R13: consecutive words of a burst come from distinct addresses
  a_r13_words_advance: assert property (@(posedge clk) disable iff (!rstN)
    dataValid && $past(dataValid) && $past(chipSel) && !$past(cfgWe) |-> dataOut != $past(dataOut));

endmodule

bind burst_read_seq burst_read_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .chipSel   (chipSel),
  .cfgWe     (cfgWe),
  .cfgRdata  (cfgRdata),
  .dataOut   (dataOut),
  .dataValid (dataValid),
  .rdyOut    (rdyOut),
  .engineBusy(engineBusy)
);

// File: tb/burst_read_seq_bench.sv
module burst_read_seq_bench;

  localparam int ADDR_W = 16;
  localparam int DATA_W = 16;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              cfgWe = 1'b0;
  logic [15:0]       cfgWdata = '0;
  logic [15:0]       cfgRdata;
  logic              chipSel = 1'b0;
  logic              addrValid = 1'b0;
  logic [ADDR_W-1:0] addrIn = '0;
  logic [DATA_W-1:0] dataOut;
  logic              dataValid;
  logic              rdyOut;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  burst_read_seq u_burst_read_seq (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgWdata(cfgWdata), .cfgRdata(cfgRdata),
    .chipSel(chipSel), .addrValid(addrValid), .addrIn(addrIn),
    .dataOut(dataOut), .dataValid(dataValid), .rdyOut(rdyOut)
  );

  function automatic logic [DATA_W-1:0] wordAt(input logic [ADDR_W-1:0] a);
    return DATA_W'(a) ^ DATA_W'(16'h5A00);
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic writeCfg(input logic [15:0] v);
    @(negedge clk);
    cfgWe = 1'b1; cfgWdata = v;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic capture(input logic [ADDR_W-1:0] a);
    @(negedge clk);
    chipSel = 1'b1; addrValid = 1'b1; addrIn = a;
    @(negedge clk);
    addrValid = 1'b0;
  endtask

  task automatic deselect();
    @(negedge clk);
    chipSel = 1'b0;
    @(negedge clk);
  endtask

  // finite burst: nLat = first-data edge, early/polHigh = expected ready behaviour
  task automatic finiteBurst(input string req, input logic [15:0] cfgVal, input int nLat,
                             input int len, input bit wrap, input bit early, input bit polHigh,
                             input logic [ADDR_W-1:0] start);
    writeCfg(cfgVal);
    capture(start);
    for (int k = 0; k <= nLat + len + 1; k++) begin
      bit expValid, expAct;
      logic [ADDR_W-1:0] ea;
      int i;
      if (k > 0) @(negedge clk);
      i = k - nLat;
      expValid = (k >= nLat) && (k < nLat + len);
      expAct = early ? ((k >= nLat - 1) && (k <= nLat + len - 2)) : expValid;
      check(req, {31'd0, dataValid}, {31'd0, expValid});
      check(req, {31'd0, rdyOut}, {31'd0, polHigh ? expAct : !expAct});
      if (expValid) begin
        if (wrap) ea = (start & ~ADDR_W'(len - 1)) | ((start + ADDR_W'(i)) & ADDR_W'(len - 1));
        else      ea = start + ADDR_W'(i);
        check(req, {16'd0, dataOut}, {16'd0, wordAt(ea)});
      end
    end
    deselect();
  endtask

  task automatic contBurst(input string req, input logic [15:0] cfgVal, input int nLat,
                           input logic [ADDR_W-1:0] start, input int words);
    writeCfg(cfgVal);
    capture(start);
    for (int k = 1; k < nLat + words; k++) begin
      @(negedge clk);
      check(req, {31'd0, dataValid}, {31'd0, k >= nLat});
      if (k >= nLat) check(req, {16'd0, dataOut}, {16'd0, wordAt(start + ADDR_W'(k - nLat))});
    end
    @(negedge clk);
    chipSel = 1'b0;
    #1;
    check("R9 abort valid", {31'd0, dataValid}, 32'd0);
    check("R9 abort ready", {31'd0, rdyOut}, 32'd0);
    @(negedge clk);
    check("R9 after abort", {31'd0, dataValid}, 32'd0);
  endtask

  task automatic testReset();
    check("R1 default cfg", {16'd0, cfgRdata}, 32'h0000AFC8);
    check("R1 valid idle", {31'd0, dataValid}, 32'd0);
    check("R1 ready idle", {31'd0, rdyOut}, 32'd0);
  endtask

  task automatic testAsync();
    capture(16'h1234);
    check("R2 async valid", {31'd0, dataValid}, 32'd1);
    check("R2 async ready", {31'd0, rdyOut}, 32'd1);
    check("R13 async word", {16'd0, dataOut}, {16'd0, wordAt(16'h1234)});
    @(negedge clk);
    check("R2 async single", {31'd0, dataValid}, 32'd0);
    deselect();
  endtask

  task automatic testReadback();
    writeCfg(16'h0000);
    check("R10 zeros", {16'd0, cfgRdata}, 32'h000002C0);
    writeCfg(16'hFFFF);
    check("R10 ones", {16'd0, cfgRdata}, 32'h0000BFCF);
  endtask

  task automatic testWriteDuringBurst();
    writeCfg(16'h1D0A);
    check("R12 setup", {16'd0, cfgRdata}, 32'h00001FCA);
    capture(16'h0040);
    @(negedge clk);
    cfgWe = 1'b1; cfgWdata = 16'h8000;
    @(negedge clk);
    cfgWe = 1'b0;
    check("R12 write ignored", {16'd0, cfgRdata}, 32'h00001FCA);
    deselect();
    check("R12 deselect keeps cfg", {16'd0, cfgRdata}, 32'h00001FCA);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testAsync();
    finiteBurst("R3 R7 wrap8 lat5", 16'h1D0A, 5, 8, 1'b1, 1'b0, 1'b1, 16'h0105);
    finiteBurst("R8 linear16 lat6", 16'h2503, 6, 16, 1'b0, 1'b0, 1'b1, 16'h001E);
    finiteBurst("R7 wrap32 lat7", 16'h2D0C, 7, 32, 1'b1, 1'b0, 1'b1, 16'h0079);
    finiteBurst("R4 R5 early low", 16'h180A, 5, 8, 1'b1, 1'b1, 1'b0, 16'h0203);
    finiteBurst("R6 lat0 aligned", 16'h040A, 2, 8, 1'b1, 1'b0, 1'b1, 16'h0033);
    contBurst("R9 continuous", 16'h2D08, 7, 16'hFFF0, 40);
    contBurst("R11 reserved codes", 16'h3501, 7, 16'h0500, 36);
    testReadback();
    testWriteDuringBurst();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule